// File: doc/BRIEF.md
# Mailbox Interrupt Control/Status Register

This block is the interrupt control and status word on the local side of a bus bridge. Events from the host-side logic are latched into six sticky flags. The events are an aborted bus cycle, a self-test start, the read transfer count reaching zero, the write transfer count reaching zero, a host read of an outgoing mailbox byte and a host write of an incoming mailbox byte. A read-only summary bit is the OR of the six flags. A registered level output copies the summary bit so that local firmware can be interrupted.

Software reaches the register through a port with a combinational read path and byte-enabled writes. Writable enable bits decide whether the two transfer-count events and the two mailbox events may set their flags. Two select fields name one of four mailboxes and one of four byte lanes in each direction. A mailbox event counts only when the host touches exactly that lane of that mailbox. Software clears a flag by writing a one to it.

Top module: `mbx_irq_csr`

## Requirements
- R1: After a synchronous reset, the register reads 0x00000000 and `irq` is 0.
- R2: Bits 31:24, bit 22, bit 13 and bits 7:5 always read as zero, and writes to them have no effect.
- R3: The control fields read back exactly as written. These are bit 15 (read-complete enable), bit 14 (write-complete enable), bit 12 (outgoing enable), bits 11:10 (outgoing mailbox), bits 9:8 (outgoing byte), bit 4 (incoming enable), bits 3:2 (incoming mailbox) and bits 1:0 (incoming byte). Byte enable bit k gates write data bits 8k+7:8k.
- R4: Bit 23 is the OR of flag bits 21:16. `irq` equals bit 23 in every cycle, and both change on the same clock edge.
- R5: Flag bits 21:16 clear when a one is written to them with byte enable 2 set. Writing a zero leaves the flag unchanged.
- R6: `ev_abort` sets bit 21 and `ev_selftest` sets bit 20 with no enable needed. The self-test flag stays set until software writes a one to it.
- R7: `ev_rd_count_zero` sets bit 19 only while bit 15 is one. `ev_wr_count_zero` sets bit 18 only while bit 14 is one.
- R8: A host read (`host_mb_rd`) with `host_mb_idx` equal to bits 11:10 and `host_mb_be` covering the lane in bits 9:8 sets bit 17, provided bit 12 is one. Mailbox codes 0 to 3 name mailboxes 1 to 4.
- R9: A host write (`host_mb_wr`) with `host_mb_idx` equal to bits 3:2 and `host_mb_be` covering the lane in bits 1:0 sets bit 16, provided bit 4 is one. Other indices, other lanes and the opposite access type have no effect.
- R10: If a set event and a write-one clear reach the same flag in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Register write byte enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register value |
| ev_abort | input | 1 | Master/target abort seen on a bridge-initiated cycle |
| ev_selftest | input | 1 | Host started a self test |
| ev_rd_count_zero | input | 1 | Read transfer count reached zero |
| ev_wr_count_zero | input | 1 | Write transfer count reached zero |
| host_mb_rd | input | 1 | Host reads an outgoing mailbox |
| host_mb_wr | input | 1 | Host writes an incoming mailbox |
| host_mb_idx | input | 2 | Mailbox number of the host access, 0 to 3 |
| host_mb_be | input | 4 | Byte lanes of the host access |
| irq | output | 1 | Registered interrupt level |

## Verification
The hardest case to reach from the ports is a host mailbox write that hits the selected lane in the same clock as a software write-one clear of that flag. The bench lines up both strobes on one cycle and then checks that the flag and `irq` are still set. Mailbox selectivity is also hard to cover. The bench points the selects at a middle mailbox and a non-zero lane. It then tries a near miss on the index, a near miss on the lane and the wrong access direction, and only after that the exact hit.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
    localparam int DW        = 32;
    localparam int NMBX      = 4;
    localparam int NLANE     = 4;
    localparam int MBXW      = $clog2(NMBX);
    localparam int LANEW     = $clog2(NLANE);
    localparam int NFLAG     = 6;

    // bit positions in the register word
    localparam int B_IN_LANE  = 0;
    localparam int B_IN_MBX   = 2;
    localparam int B_IN_EN    = 4;
    localparam int B_OUT_LANE = 8;
    localparam int B_OUT_MBX  = 10;
    localparam int B_OUT_EN   = 12;
    localparam int B_WRC_EN   = 14;
    localparam int B_RDC_EN   = 15;
    localparam int B_FLAG_LO  = 16;
    localparam int B_SUMMARY  = 23;

    // flag index, offset from B_FLAG_LO
    localparam int F_IN   = 0;
    localparam int F_OUT  = 1;
    localparam int F_WRC  = 2;
    localparam int F_RDC  = 3;
    localparam int F_BIST = 4;
    localparam int F_ABT  = 5;

    localparam logic [DW-1:0] RSVD_MASK = 32'hFF40_20E0;

    typedef struct packed {
        logic             rdc_en;
        logic             wrc_en;
        logic             out_en;
        logic [MBXW-1:0]  out_mbx;
        logic [LANEW-1:0] out_lane;
        logic             in_en;
        logic [MBXW-1:0]  in_mbx;
        logic [LANEW-1:0] in_lane;
    } ctl_t;

    typedef struct packed {
        ctl_t ctl;
        logic irq;
    } csr_state_t;
endpackage

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_d,
    output logic flag_q
);
    always_comb begin
        flag_d = set_i | (flag_q & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    // R10: a set event always leaves the flag high
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);
    // R5: clear without set drops the flag
    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_q);
    // R5: no clear and no set holds the flag
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/mbx_lane_hit.sv
module mbx_lane_hit #(
    parameter int NMBX  = 4,
    parameter int NLANE = 4,
    localparam int MBXW  = $clog2(NMBX),
    localparam int LANEW = $clog2(NLANE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_i,
    input  logic             en_i,
    input  logic [MBXW-1:0]  acc_idx_i,
    input  logic [NLANE-1:0] acc_be_i,
    input  logic [MBXW-1:0]  sel_mbx_i,
    input  logic [LANEW-1:0] sel_lane_i,
    output logic             hit_o
);
    logic [NMBX-1:0]  mbx_match;
    logic [NLANE-1:0] lane_match;

    for (genvar m = 0; m < NMBX; m++) begin : g_mbx
        assign mbx_match[m] = (acc_idx_i == MBXW'(m)) && (sel_mbx_i == MBXW'(m));
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign lane_match[l] = acc_be_i[l] && (sel_lane_i == LANEW'(l));
    end

    always_comb begin
        hit_o = strobe_i & en_i & (|mbx_match) & (|lane_match);
    end

    // R8, R9: at most one mailbox can match a single access
    p_one_mbx_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mbx_match));
    // R8, R9: no hit without an access strobe
    p_hit_needs_access_r9: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |-> !hit_o);
endmodule

// File: rtl/mbx_irq_csr.sv
module mbx_irq_csr
    import mbx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [NLANE-1:0]  reg_be,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              ev_abort,
    input  logic              ev_selftest,
    input  logic              ev_rd_count_zero,
    input  logic              ev_wr_count_zero,
    input  logic              host_mb_rd,
    input  logic              host_mb_wr,
    input  logic [MBXW-1:0]   host_mb_idx,
    input  logic [NLANE-1:0]  host_mb_be,
    output logic              irq
);
    csr_state_t       st_d, st_q;
    logic [NFLAG-1:0] flag_set, flag_clr, flag_d, flag_q;
    logic             in_hit, out_hit;

    mbx_lane_hit #(.NMBX(NMBX), .NLANE(NLANE)) u_in_hit (
        .clk(clk), .rst(rst),
        .strobe_i(host_mb_wr), .en_i(st_q.ctl.in_en),
        .acc_idx_i(host_mb_idx), .acc_be_i(host_mb_be),
        .sel_mbx_i(st_q.ctl.in_mbx), .sel_lane_i(st_q.ctl.in_lane),
        .hit_o(in_hit)
    );

    mbx_lane_hit #(.NMBX(NMBX), .NLANE(NLANE)) u_out_hit (
        .clk(clk), .rst(rst),
        .strobe_i(host_mb_rd), .en_i(st_q.ctl.out_en),
        .acc_idx_i(host_mb_idx), .acc_be_i(host_mb_be),
        .sel_mbx_i(st_q.ctl.out_mbx), .sel_lane_i(st_q.ctl.out_lane),
        .hit_o(out_hit)
    );

    always_comb begin
        flag_set         = '0;
        flag_set[F_IN]   = in_hit;
        flag_set[F_OUT]  = out_hit;
        flag_set[F_WRC]  = ev_wr_count_zero & st_q.ctl.wrc_en;
        flag_set[F_RDC]  = ev_rd_count_zero & st_q.ctl.rdc_en;
        flag_set[F_BIST] = ev_selftest;
        flag_set[F_ABT]  = ev_abort;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign flag_clr[i] = reg_wr & reg_be[B_FLAG_LO/8] & reg_wdata[B_FLAG_LO+i];
        mbx_irq_flag u_flag (
            .clk(clk), .rst(rst),
            .set_i(flag_set[i]), .clr_i(flag_clr[i]),
            .flag_d(flag_d[i]), .flag_q(flag_q[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_be[0]) begin
            st_d.ctl.in_en   = reg_wdata[B_IN_EN];
            st_d.ctl.in_mbx  = reg_wdata[B_IN_MBX +: MBXW];
            st_d.ctl.in_lane = reg_wdata[B_IN_LANE +: LANEW];
        end
        if (reg_wr && reg_be[1]) begin
            st_d.ctl.rdc_en   = reg_wdata[B_RDC_EN];
            st_d.ctl.wrc_en   = reg_wdata[B_WRC_EN];
            st_d.ctl.out_en   = reg_wdata[B_OUT_EN];
            st_d.ctl.out_mbx  = reg_wdata[B_OUT_MBX +: MBXW];
            st_d.ctl.out_lane = reg_wdata[B_OUT_LANE +: LANEW];
        end
        st_d.irq = |flag_d;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        reg_rdata                          = '0;
        reg_rdata[B_IN_LANE +: LANEW]      = st_q.ctl.in_lane;
        reg_rdata[B_IN_MBX +: MBXW]        = st_q.ctl.in_mbx;
        reg_rdata[B_IN_EN]                 = st_q.ctl.in_en;
        reg_rdata[B_OUT_LANE +: LANEW]     = st_q.ctl.out_lane;
        reg_rdata[B_OUT_MBX +: MBXW]       = st_q.ctl.out_mbx;
        reg_rdata[B_OUT_EN]                = st_q.ctl.out_en;
        reg_rdata[B_WRC_EN]                = st_q.ctl.wrc_en;
        reg_rdata[B_RDC_EN]                = st_q.ctl.rdc_en;
        reg_rdata[B_FLAG_LO +: NFLAG]      = flag_q;
        reg_rdata[B_SUMMARY]               = |flag_q;
    end

    assign irq = st_q.irq;

    // R2: reserved bits never read as one
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & RSVD_MASK) == '0);
    // R4: the registered output tracks the summary bit
    p_irq_summary_r4: assert property (@(posedge clk) disable iff (rst)
        irq == reg_rdata[B_SUMMARY]);
    // R7: a disabled read-complete flag that is low stays low
    p_rdc_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (!st_q.ctl.rdc_en && !flag_q[F_RDC]) |=> !flag_q[F_RDC]);
    // R6: the self-test flag is sticky until a one is written to it
    p_bist_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q[F_BIST] && !flag_clr[F_BIST]) |=> flag_q[F_BIST]);
endmodule

// File: tb/mbx_irq_csr_test.sv
module mbx_irq_csr_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [3:0]  reg_be;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        ev_abort, ev_selftest, ev_rd_count_zero, ev_wr_count_zero;
    logic        host_mb_rd, host_mb_wr;
    logic [1:0]  host_mb_idx;
    logic [3:0]  host_mb_be;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mbx_irq_csr uut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_abort(ev_abort), .ev_selftest(ev_selftest),
        .ev_rd_count_zero(ev_rd_count_zero), .ev_wr_count_zero(ev_wr_count_zero),
        .host_mb_rd(host_mb_rd), .host_mb_wr(host_mb_wr),
        .host_mb_idx(host_mb_idx), .host_mb_be(host_mb_be),
        .irq(irq)
    );

    // {wdata, byte enables, expected readback}
    localparam int NVEC = 6;
    localparam logic [67:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 4'b0011, 32'h0000_DF1F},
        {32'h0000_0000, 4'b0001, 32'h0000_DF00},
        {32'h0000_A5FF, 4'b0010, 32'h0000_8500},
        {32'h0000_0016, 4'b1111, 32'h0000_0016},
        {32'hFFFF_0000, 4'b1100, 32'h0000_0016},
        {32'h0000_0000, 4'b1111, 32'h0000_0000}
    };

    task automatic check(input logic [31:0] exp_d, input logic exp_irq, input string req);
        n_cmp++;
        if (reg_rdata !== exp_d || irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, reg_rdata, irq, exp_d, exp_irq);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_be = 0; reg_wdata = 0;
        ev_abort = 0; ev_selftest = 0; ev_rd_count_zero = 0; ev_wr_count_zero = 0;
        host_mb_rd = 0; host_mb_wr = 0; host_mb_idx = 0; host_mb_be = 0;
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be);
        reg_wr = 1; reg_wdata = d; reg_be = be;
        @(negedge clk);
        idle();
    endtask

    task automatic host(input logic rd, input logic [1:0] idx, input logic [3:0] be);
        host_mb_rd = rd; host_mb_wr = ~rd; host_mb_idx = idx; host_mb_be = be;
        @(negedge clk);
        idle();
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check(32'h0, 1'b0, "R1 reset value");

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][67:36], VEC[i][35:32]);
            check(VEC[i][31:0], 1'b0, "R2/R3 table write");
        end

        // R6 abort, R4 irq, R5 zero-write leaves flag
        ev_abort = 1; @(negedge clk); idle();
        check(32'h00A0_0000, 1'b1, "R6 abort sets");
        wr(32'h0000_0000, 4'b1111);
        check(32'h00A0_0000, 1'b1, "R5 zero write keeps flag");
        wr(32'h0020_0000, 4'b1011);
        check(32'h00A0_0000, 1'b1, "R5 clear needs byte enable 2");
        wr(32'h0020_0000, 4'b0100);
        check(32'h0000_0000, 1'b0, "R5 one clears abort, R4 irq falls");

        // R6 self test sticky
        ev_selftest = 1; @(negedge clk); idle();
        repeat (4) @(negedge clk);
        check(32'h0090_0000, 1'b1, "R6 self-test sticky");
        wr(32'h0010_0000, 4'b0100);
        check(32'h0000_0000, 1'b0, "R5 self-test cleared");

        // R7 enables
        ev_rd_count_zero = 1; ev_wr_count_zero = 1; @(negedge clk); idle();
        check(32'h0000_0000, 1'b0, "R7 count events masked");
        wr(32'h0000_8000, 4'b0010);
        ev_rd_count_zero = 1; ev_wr_count_zero = 1; @(negedge clk); idle();
        check(32'h0088_8000, 1'b1, "R7 read-complete only");
        wr(32'h0000_4000, 4'b0010);
        ev_wr_count_zero = 1; @(negedge clk); idle();
        check(32'h008C_4000, 1'b1, "R7 write-complete with bit 14");
        wr(32'h000C_0000, 4'b0110);
        check(32'h0000_0000, 1'b0, "R5 clear both complete flags");

        // R8 outgoing: mailbox code 2, lane 1, enabled
        wr(32'h0000_1900, 4'b0010);
        host(1'b1, 2'd2, 4'b1101);
        host(1'b1, 2'd1, 4'b0010);
        host(1'b0, 2'd2, 4'b0010);
        check(32'h0000_1900, 1'b0, "R8 near misses ignored");
        host(1'b1, 2'd2, 4'b0010);
        check(32'h0082_1900, 1'b1, "R8 outgoing hit");
        wr(32'h0002_0000, 4'b0100);
        check(32'h0000_1900, 1'b0, "R5 outgoing cleared");

        // R9 incoming: mailbox code 3, lane 0, enabled
        wr(32'h0000_001C, 4'b0001);
        host(1'b1, 2'd3, 4'b0001);
        host(1'b0, 2'd3, 4'b1110);
        host(1'b0, 2'd0, 4'b0001);
        check(32'h0000_191C, 1'b0, "R9 near misses ignored");
        host(1'b0, 2'd3, 4'b0001);
        check(32'h0081_191C, 1'b1, "R9 incoming hit");

        // R10 set and clear in the same cycle
        reg_wr = 1; reg_be = 4'b0100; reg_wdata = 32'h0001_0000;
        host_mb_wr = 1; host_mb_idx = 2'd3; host_mb_be = 4'b0001;
        @(negedge clk); idle();
        check(32'h0081_191C, 1'b1, "R10 set beats clear");
        wr(32'h0001_0000, 4'b0100);
        check(32'h0000_191C, 1'b0, "R10 later clear works");

        // R1 reset from a busy state
        ev_abort = 1; @(negedge clk); idle();
        rst = 1; @(negedge clk); rst = 0;
        check(32'h0, 1'b0, "R1 reset clears all");

        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule